// File: doc/BRIEF.md
# Adaptive Triangular Dither Generator

This block spreads the switching spectrum of a variable-frequency flyback controller. It adds a triangular offset to a digital peak-current command word and passes the sum to the modulator. The triangle repeats at about 23 kHz, which is above the audible band and above the regulation loop's bandwidth. The triangle is centred on zero, so the average command does not move.

Two sampled sense codes shape the dither. An output-voltage code is taken only while a strobe marks the demagnetization interval. It selects a small or a large peak-to-peak amplitude through a hysteresis band. A line-sense current code turns dither on or off through a second, separate hysteresis band, so dither is off at low line. A new amplitude or enable state takes effect only when the triangle crosses zero. This keeps the command free of steps.

The dithered command is then clipped between two levels. A lower burst-entry level and an upper power-limit level bound the result. Near either boundary the dither is cut away, so it changes neither peak power nor burst behaviour.

Top module: `dither_shaper`

## Requirements
- R1: The offset is a triangle centred on zero with a 16-bit fractional step `step = (amp_pp * 2^15) / Q`, where `Q = CLK_HZ / (4*DITH_HZ)`. Its largest value is `floor(Q*step / 2^16)` and its smallest is `-ceil(Q*step / 2^16)`.
- R2: The triangle period is exactly `4*Q` clocks: 2172 clocks at 50 MHz, about 23.0 kHz. Upward zero crossings of the offset are `4*Q` clocks apart.
- R3: When `vs_strobe` is high, the amplitude selection changes as follows. A `vs_code` below `VS_LO` (480) selects the small amplitude, and a code above `VS_HI` (500) selects the large amplitude. Codes from 480 to 500 inclusive keep the previous selection. While `vs_strobe` is low, `vs_code` is ignored.
- R4: The default peak-to-peak amplitudes are 36 LSB (small) and 98 LSB (large).
- R5: Dither turns on when `ls_code` is above `LS_ON` (646) and turns off when it is below `LS_OFF` (580). Codes from 580 to 646 inclusive keep the previous state.
- R6: Amplitude and enable changes take effect only at a triangle zero crossing. The offset therefore never changes by more than 1 LSB from one clock to the next, including when dither is switched off.
- R7: `cmd_out` never exceeds `max_lvl`.
- R8: When `burst_lvl <= max_lvl`, `cmd_out` is never below `burst_lvl`.
- R9: When `burst_lvl > max_lvl`, the upper level wins and `cmd_out` equals `max_lvl`.
- R10: With dither off, `cmd_out` equals `cmd_in` clipped to the range from `burst_lvl` to `max_lvl`, one clock after the inputs.
- R11: Reset drives `cmd_out` to 0. It also selects the small amplitude, disables dither and clears the triangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | CMD_W | Peak-current command, unsigned |
| vs_code | input | VS_W | Output-voltage code taken during demagnetization |
| vs_strobe | input | 1 | Marks a valid `vs_code` sample |
| ls_code | input | LS_W | Line-sense current code |
| max_lvl | input | CMD_W | Upper clip (power limit) |
| burst_lvl | input | CMD_W | Lower clip (burst entry) |
| cmd_out | output | CMD_W | Dithered and clipped command, registered |

## Verification
A wrong amplitude or enable register shows up at `cmd_out` no later than the next zero crossing, which is at most half a triangle period away. It appears as a peak offset that differs from the values in R1. A phase counter that wraps at the wrong count shifts the distance between upward crossings, which is visible within two periods. A gating fault that lets a change happen mid-slope shows up at once as a jump of more than one LSB in the offset. A clip fault is visible in the very cycle after the command crosses a level.

// File: rtl/dith_pkg.sv
package dith_pkg;

  // fractional bits of the triangle accumulator
  localparam int FRAC_W = 16;

  // clocks in one quarter of the triangle
  function automatic int quarter_len(input int clk_hz, input int dith_hz);
    return clk_hz / (4 * dith_hz);
  endfunction

  // per-clock accumulator increment for a peak-to-peak amplitude
  function automatic int tri_step(input int amp_pp, input int qlen);
    return (amp_pp * (1 << (FRAC_W - 1))) / qlen;
  endfunction

  // largest whole offset reached by a given step
  function automatic int tri_peak(input int step, input int qlen);
    return (qlen * step) >>> FRAC_W;
  endfunction

  // lower clip first, upper clip last so the upper level wins
  function automatic int clip_cmd(input int sum, input int lo, input int hi);
    int t;
    t = (sum < lo) ? lo : sum;
    return (t > hi) ? hi : t;
  endfunction

  typedef enum logic {AMP_SMALL_SEL = 1'b0, AMP_LARGE_SEL = 1'b1} amp_sel_e;

endpackage

// File: rtl/dith_hyst.sv
module dith_hyst #(
  parameter int W  = 10,
  parameter int LO = 480,
  parameter int HI = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic [W-1:0] code,
  output logic         state
);

  logic go_high;
  logic go_low;

  assign go_high = sample && (code > W'(HI));
  assign go_low  = sample && (code < W'(LO));

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= 1'b0;
    else if (go_high) state <= 1'b1;
    else if (go_low)  state <= 1'b0;
  end

  // R3 R5
  hyst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && code > W'(HI)) |=> state);
  // R3 R5
  hyst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && code < W'(LO)) |=> !state);
  // R3 R5
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample || (code >= W'(LO) && code <= W'(HI))) |=> $stable(state));

endmodule

// File: rtl/dith_tri.sv
module dith_tri
  import dith_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int DITH_HZ   = 23_000,
  parameter int AMP_SMALL = 36,
  parameter int AMP_LARGE = 98,
  parameter int OFF_W     = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    amp_req,
  input  logic                    en_req,
  output logic signed [OFF_W-1:0] offset,
  output logic                    zc,
  output logic                    en_act
);

  localparam int QLEN   = quarter_len(CLK_HZ, DITH_HZ);
  localparam int PER    = 4 * QLEN;
  localparam int CNT_W  = $clog2(PER);
  localparam int ACC_W  = FRAC_W + OFF_W;
  localparam int STEP_S = tri_step(AMP_SMALL, QLEN);
  localparam int STEP_L = tri_step(AMP_LARGE, QLEN);
  localparam int PEAK_L = tri_peak((STEP_L > STEP_S) ? STEP_L : STEP_S, QLEN);

  logic [CNT_W-1:0]        cnt;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] step_sel;
  amp_sel_e                amp_act;
  amp_sel_e                amp_nxt;
  logic                    en_nxt;
  logic                    rising;

  assign zc     = (cnt == '0) || (cnt == CNT_W'(2 * QLEN));
  assign rising = (cnt < CNT_W'(QLEN)) || (cnt >= CNT_W'(3 * QLEN));

  always_comb begin
    en_nxt  = zc ? en_req : en_act;
    amp_nxt = zc ? amp_sel_e'(amp_req) : amp_act;
  end

  generate
    if (STEP_S == STEP_L) begin : g_one_step
      assign step_sel = ACC_W'(STEP_S);
    end else begin : g_two_step
      assign step_sel = (amp_nxt == AMP_LARGE_SEL) ? ACC_W'(STEP_L) : ACC_W'(STEP_S);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      en_act  <= 1'b0;
      amp_act <= AMP_SMALL_SEL;
    end else begin
      cnt     <= (cnt == CNT_W'(PER - 1)) ? '0 : cnt + 1'b1;
      en_act  <= en_nxt;
      amp_act <= amp_nxt;
      if (!en_nxt)     acc <= '0;
      else if (rising) acc <= acc + step_sel;
      else             acc <= acc - step_sel;
    end
  end

  // arithmetic shift then keep the integer part
  assign offset = acc[FRAC_W +: OFF_W];

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |-> (acc == '0));
  // R6
  zc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zc |=> ($stable(en_act) && $stable(amp_act)));
  // R2
  zero_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (acc == '0));
  // R1
  amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset <= OFF_W'(PEAK_L)) && (offset >= -OFF_W'(PEAK_L + 1)));
  // R6
  slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((offset - $past(offset)) <= OFF_W'(1)) && (($past(offset) - offset) <= OFF_W'(1)));

endmodule

// File: rtl/dith_clip.sv
module dith_clip
  import dith_pkg::*;
#(
  parameter int CMD_W = 12,
  parameter int OFF_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CMD_W-1:0]        cmd,
  input  logic signed [OFF_W-1:0] offset,
  input  logic [CMD_W-1:0]        hi_lvl,
  input  logic [CMD_W-1:0]        lo_lvl,
  output logic [CMD_W-1:0]        out
);

  int sum;
  int clipped;

  always_comb begin
    sum     = int'(cmd) + int'(offset);
    clipped = clip_cmd(sum, int'(lo_lvl), int'(hi_lvl));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out <= '0;
    else        out <= clipped[CMD_W-1:0];
  end

  // R7
  upper_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (out <= $past(hi_lvl)));
  // R8
  lower_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_lvl <= hi_lvl) |=> (out >= $past(lo_lvl)));
  // R9
  crossed_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_lvl > hi_lvl) |=> (out == $past(hi_lvl)));

endmodule

// File: rtl/dither_shaper.sv
module dither_shaper #(
  parameter int CMD_W     = 12,
  parameter int VS_W      = 10,
  parameter int LS_W      = 10,
  parameter int CLK_HZ    = 50_000_000,
  parameter int DITH_HZ   = 23_000,
  parameter int AMP_SMALL = 36,
  parameter int AMP_LARGE = 98,
  parameter int VS_LO     = 480,
  parameter int VS_HI     = 500,
  parameter int LS_OFF    = 580,
  parameter int LS_ON     = 646
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic [VS_W-1:0]  vs_code,
  input  logic             vs_strobe,
  input  logic [LS_W-1:0]  ls_code,
  input  logic [CMD_W-1:0] max_lvl,
  input  logic [CMD_W-1:0] burst_lvl,
  output logic [CMD_W-1:0] cmd_out
);

  localparam int OFF_W = CMD_W + 1;

  // named internal events for the checks
  logic                    amp_large_req;
  logic                    dith_on_req;
  logic                    dith_on;
  logic                    zero_cross;
  logic signed [OFF_W-1:0] tri_off;

  dith_hyst #(.W(VS_W), .LO(VS_LO), .HI(VS_HI)) amp_hyst_i (
    .clk(clk), .rst_n(rst_n), .sample(vs_strobe), .code(vs_code), .state(amp_large_req)
  );

  dith_hyst #(.W(LS_W), .LO(LS_OFF), .HI(LS_ON)) line_hyst_i (
    .clk(clk), .rst_n(rst_n), .sample(1'b1), .code(ls_code), .state(dith_on_req)
  );

  dith_tri #(
    .CLK_HZ(CLK_HZ), .DITH_HZ(DITH_HZ), .AMP_SMALL(AMP_SMALL),
    .AMP_LARGE(AMP_LARGE), .OFF_W(OFF_W)
  ) tri_i (
    .clk(clk), .rst_n(rst_n), .amp_req(amp_large_req), .en_req(dith_on_req),
    .offset(tri_off), .zc(zero_cross), .en_act(dith_on)
  );

  dith_clip #(.CMD_W(CMD_W), .OFF_W(OFF_W)) clip_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_in), .offset(tri_off),
    .hi_lvl(max_lvl), .lo_lvl(burst_lvl), .out(cmd_out)
  );

  // R10
  off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_on |-> (tri_off == '0));
  // R6
  enable_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dith_on != dith_on_req) && !zero_cross |=> (dith_on == $past(dith_on)));

endmodule

// File: tb/dither_shaper_tb.sv
module dither_shaper_tb_top;

  localparam int CLK_HZ  = 50_000_000;
  localparam int DITH_HZ = 23_000;
  localparam int Q       = CLK_HZ / (4 * DITH_HZ);
  localparam int P       = 4 * Q;
  localparam int MID     = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cmd_in = 12'(MID);
  logic [9:0]  vs_code = '0;
  logic        vs_strobe = 1'b0;
  logic [9:0]  ls_code = '0;
  logic [11:0] max_lvl = 12'd4095;
  logic [11:0] burst_lvl = '0;
  logic [11:0] cmd_out;

  int n_tests = 0;
  int n_fail  = 0;
  int jumps   = 0;

  always #10 clk = ~clk;

  dither_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .vs_code(vs_code), .vs_strobe(vs_strobe),
    .ls_code(ls_code), .max_lvl(max_lvl), .burst_lvl(burst_lvl), .cmd_out(cmd_out)
  );

  // expected extremes, restated as plain integer arithmetic
  function automatic int exp_hi(input int amp);
    int st;
    st = (amp * 32768) / Q;
    return (Q * st) / 65536;
  endfunction

  function automatic int exp_lo(input int amp);
    int st;
    st = (amp * 32768) / Q;
    return -((Q * st + 65535) / 65536);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // watch the offset around MID for a number of clocks
  task automatic observe(input int cycles, output int mn, output int mx, output int per);
    int prev, cur, last_up;
    mn = 1 << 30; mx = -(1 << 30); per = -1; last_up = -1; prev = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cur = int'(cmd_out) - MID;
      if (cur < mn) mn = cur;
      if (cur > mx) mx = cur;
      if (i > 0) begin
        if (prev < 0 && cur >= 0) begin
          if (last_up >= 0) per = i - last_up;
          last_up = i;
        end
        if (cur - prev > 1 || prev - cur > 1) jumps++;
      end
      prev = cur;
    end
  endtask

  task automatic pulse_vs(input int v);
    @(negedge clk);
    vs_code = 10'(v); vs_strobe = 1'b1;
    @(negedge clk);
    vs_strobe = 1'b0;
  endtask

  task automatic expect_amp(input int amp, input string req);
    int mn, mx, per;
    observe(P + 10, mn, mx, per);
    observe(2 * P + 20, mn, mx, per);
    check(mx == exp_hi(amp), req, mx, exp_hi(amp));
    check(mn == exp_lo(amp), req, mn, exp_lo(amp));
  endtask

  task automatic expect_flat(input string req);
    int mn, mx, per;
    observe(P + 10, mn, mx, per);
    observe(P + 10, mn, mx, per);
    check(mn == 0 && mx == 0, req, mx - mn, 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int mn, mx, per, bad, e, o;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(cmd_out == 0, "R11 reset output", int'(cmd_out), 0);
    rst_n = 1'b1;
    expect_flat("R11 dither off after reset");

    // R5 hold at upper boundary, then enable
    ls_code = 10'd646;
    expect_flat("R5 code 646 holds off");
    ls_code = 10'd647;
    observe(P + 10, mn, mx, per);
    observe(2 * P + 20, mn, mx, per);
    check(mx == exp_hi(36), "R4 R11 small peak", mx, exp_hi(36));
    check(mn == exp_lo(36), "R4 R1 small trough", mn, exp_lo(36));
    check(per == P, "R2 period", per, P);
    e = CLK_HZ - per * DITH_HZ;
    check(e <= 4 * DITH_HZ && e >= -4 * DITH_HZ, "R2 near 23 kHz", per * DITH_HZ, CLK_HZ);

    // R3 amplitude hysteresis
    pulse_vs(500);
    expect_amp(36, "R3 code 500 holds small");
    pulse_vs(501);
    expect_amp(98, "R3 R4 code 501 selects large");
    pulse_vs(480);
    expect_amp(98, "R3 code 480 holds large");
    @(negedge clk); vs_code = 10'd100;
    expect_amp(98, "R3 no strobe ignored");
    pulse_vs(479);
    expect_amp(36, "R3 code 479 selects small");

    // R5 lower boundary, then disable with fade
    pulse_vs(700);
    ls_code = 10'd580;
    expect_amp(98, "R5 code 580 holds on");
    ls_code = 10'd579;
    expect_flat("R5 code 579 disables");
    check(jumps == 0, "R6 no offset step", jumps, 0);

    // re-enable large dither for clip sweeps
    ls_code = 10'd700;
    observe(P + 10, mn, mx, per);

    // R7 R8 narrow window sweep
    max_lvl = 12'd2040; burst_lvl = 12'd1960; bad = 0;
    for (int c = 1800; c <= 2200; c++) begin
      @(negedge clk); cmd_in = 12'(c);
      @(negedge clk);
      o = int'(cmd_out);
      if (o > 2040 || o < 1960) bad++;
      else if (c >= 2040 + 50 && o != 2040) bad++;
      else if (c <= 1960 - 50 && o != 1960) bad++;
      else if (o - c > 48 || c - o > 49) begin
        if (c > 1960 + 49 && c < 2040 - 49) bad++;
      end
    end
    check(bad == 0, "R7 R8 narrow window", bad, 0);

    // R7 R8 full range with rails
    max_lvl = 12'd4095; burst_lvl = 12'd0; bad = 0;
    for (int c = 0; c < 4096; c++) begin
      int lo, hi;
      @(negedge clk); cmd_in = 12'(c);
      @(negedge clk);
      o = int'(cmd_out);
      lo = (c - 49 < 0) ? 0 : c - 49;
      hi = (c + 48 > 4095) ? 4095 : c + 48;
      if (o < lo || o > hi) bad++;
    end
    check(bad == 0, "R7 R8 full range", bad, 0);

    // R9 crossed levels
    max_lvl = 12'd2500; burst_lvl = 12'd3000; bad = 0;
    for (int c = 0; c < 4096; c += 16) begin
      @(negedge clk); cmd_in = 12'(c);
      @(negedge clk);
      if (cmd_out != 12'd2500) bad++;
    end
    check(bad == 0, "R9 upper wins", bad, 0);

    // R10 dither off: exact clip of the command
    ls_code = 10'd0;
    cmd_in = 12'(MID); max_lvl = 12'd4095; burst_lvl = 12'd0;
    observe(P + 10, mn, mx, per);
    max_lvl = 12'd3000; burst_lvl = 12'd1000; bad = 0;
    for (int c = 0; c < 4096; c += 7) begin
      int ex;
      @(negedge clk); cmd_in = 12'(c);
      @(negedge clk);
      ex = (c < 1000) ? 1000 : ((c > 3000) ? 3000 : c);
      if (int'(cmd_out) != ex) begin
        bad++;
        if (bad == 1) $display("FAIL R10 cmd=%0d actual=%0d expected=%0d", c, cmd_out, ex);
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule